// File: doc/BRIEF.md
# Boundary-Conduction PFC Cycle Controller

This block produces the gate-drive pulse for a boost power-factor stage that runs in boundary (critical) conduction. Each switching cycle begins when the inductor current has returned to zero. An auxiliary-winding detector, reduced to two digital comparator flags, first arms the block when its voltage rises past an upper level. The cycle then starts when the voltage falls through a lower level. A restart watchdog starts a cycle by itself when the detector stays silent for too long. The watchdog can be parked by keeping the detector input high, which stops switching.

The on-time comes from a ramp counter that advances once per clock while the drive is high. The pulse ends at the first of these events: the ramp plus a fixed base reaches the control word, the ramp reaches its peak limit, an overcurrent flag arrives after the leading-edge blanking window, an overvoltage flag is asserted, or the supply sequencer withdraws its enable. A control word at or below the base gives zero duty. Overvoltage blocks new pulses only while it is asserted. Undervoltage holds the watchdog cleared.

All inputs are synchronous digital flags. The analog comparators, the error amplifier and the gate driver sit outside this block.

Top module: `crm_pfc_ctrl`

## Requirements
- R1: During reset, gate_drive is 0. When seq_en is sampled low, gate_drive is 0 from the next clock edge. While seq_en is low no pulse starts. Returning to seq_en high leaves the detector unarmed, so a rising zcd_below_trig without a prior zcd_above_arm starts nothing.
- R2: The detector arms when zcd_above_arm is sampled high while the drive is low. A later 0-to-1 change of zcd_below_trig, sampled on edge E, raises gate_drive on edge E.
- R3: A 0-to-1 change of zcd_below_trig is ignored in two cases: while the drive is high, and after a pulse ends but before zcd_above_arm has been seen again with the drive low.
- R4: With BASE = CTRL_FLOOR + RAMP_OFFSET (default 24), the pulse lasts ctrl_word − BASE clock cycles. The ramp restarts from zero on every pulse, so equal control words give equal widths.
- R5: No pulse lasts longer than RAMP_PEAK cycles (default 100).
- R6: If ctrl_word ≤ BASE, no pulse starts, whether the request comes from the detector or from the watchdog.
- R7: A high oc_flag sampled on an edge ends the pulse on that edge, unless fewer than BLANK_CYC + 1 cycles of the pulse have elapsed. With oc_flag high from the start, the pulse lasts BLANK_CYC + 1 cycles (default 6). An oc_flag burst inside the blanking window has no effect.
- R8: While ov_flag is high, no pulse starts, and an active pulse ends on the next edge. Once ov_flag is low, pulses start again without any clearing action.
- R9: If no pulse starts, the watchdog starts one WD_TIMEOUT cycles (default 300) after the previous pulse start. This repeats while zcd_below_trig stays high.
- R10: After zcd_above_arm has been seen, the watchdog stops counting until zcd_below_trig is seen. Holding the detector high therefore stops all switching.
- R11: A high uv_flag keeps the watchdog cleared. The next watchdog pulse starts WD_TIMEOUT edges after the last edge on which uv_flag was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_en | input | 1 | Enable from the supply sequencer |
| zcd_above_arm | input | 1 | Detector input is above the arming level |
| zcd_below_trig | input | 1 | Detector input is below the trigger level |
| oc_flag | input | 1 | Switch current is above its limit |
| ov_flag | input | 1 | Output overvoltage |
| uv_flag | input | 1 | Output undervoltage |
| ctrl_word | input | CTRL_W | On-time control value |
| gate_drive | output | 1 | Registered boost switch drive |

## Verification
An error in the ramp counter or its comparisons shows up on the falling edge of the first affected pulse, as a width that differs from ctrl_word − BASE, the peak, the blanking length or the fault cycle. An arming or edge-detect error shows up as a start one cycle off, a missing pulse, or a pulse where a trigger should have been ignored. A watchdog count that is not cleared, or that keeps running while parked, moves or adds a start hundreds of cycles later. The bench therefore checks the position of every start and watches for extra pulses over long windows.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    START_NONE = 2'd0,
    START_ZCD  = 2'd1,
    START_WDOG = 2'd2
  } start_cause_e;

endpackage

// File: rtl/pfc_zcd_arm.sv
module pfc_zcd_arm (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic above,
  input  logic below,
  input  logic busy,
  input  logic start,
  output logic trig,
  output logic park
);

  logic armed;
  logic below_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      below_q <= 1'b0;
    end else begin
      below_q <= below;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      armed <= 1'b0;
    end else if (start) begin
      armed <= 1'b0;
    end else if (above && !busy) begin
      armed <= 1'b1;
    end
  end

  // watchdog suspend: set by arming level, released by trigger level
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      park <= 1'b0;
    end else if (below) begin
      park <= 1'b0;
    end else if (above) begin
      park <= 1'b1;
    end
  end

  assign trig = armed && below && !below_q && !busy;

  // R3: every pulse start consumes the arming
  p_arm_consumed_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> !armed);

endmodule

// File: rtl/pfc_restart_wdog.sv
module pfc_restart_wdog #(
  parameter int WD_TIMEOUT = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic park,
  input  logic uv,
  input  logic start,
  output logic fire
);

  localparam int WD_W = $clog2(WD_TIMEOUT + 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_TIMEOUT - 1);

  logic [WD_W-1:0] cnt;
  logic            run;

  assign run  = en && !park && !uv;
  assign fire = run && (cnt == WD_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en || uv || start) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == WD_LAST) cnt <= '0;
      else                cnt <= cnt + 1'b1;
    end
  end

  p_wd_bound_r9: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < WD_TIMEOUT);

  p_uv_clears_r11: assert property (@(posedge clk) disable iff (rst)
    uv |=> (cnt == '0));

endmodule

// File: rtl/pfc_ontime.sv
module pfc_ontime #(
  parameter int CTRL_W    = 8,
  parameter int BASE      = 24,
  parameter int RAMP_PEAK = 100,
  parameter int BLANK_CYC = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              oc,
  input  logic              ov,
  output logic              active
);

  localparam int RAMP_W = $clog2(RAMP_PEAK + 1);

  logic [RAMP_W-1:0] ramp;
  logic hit_ctrl, hit_peak, oc_live, stop;

  assign hit_ctrl = (32'(ramp) + 32'd1 + 32'(BASE)) >= 32'(ctrl);
  assign hit_peak = (32'(ramp) + 32'd1) >= 32'(RAMP_PEAK);
  assign oc_live  = oc && (32'(ramp) >= 32'(BLANK_CYC));
  assign stop     = ov || hit_ctrl || hit_peak || oc_live;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active <= 1'b0;
      ramp   <= '0;
    end else if (!active) begin
      ramp <= '0;
      if (start) active <= 1'b1;
    end else if (stop) begin
      active <= 1'b0;
      ramp   <= '0;
    end else begin
      ramp <= ramp + 1'b1;
    end
  end

  p_ramp_cap_r5: assert property (@(posedge clk) disable iff (rst)
    active |-> (32'(ramp) < 32'(RAMP_PEAK)));

  p_ramp_idle_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> (ramp == '0));

  p_ov_ends_r8: assert property (@(posedge clk) disable iff (rst)
    (active && ov) |=> !active);

endmodule

// File: rtl/crm_pfc_ctrl.sv
module crm_pfc_ctrl
  import pfc_pkg::*;
#(
  parameter int CTRL_W      = 8,
  parameter int CTRL_FLOOR  = 16,
  parameter int RAMP_OFFSET = 8,
  parameter int RAMP_PEAK   = 100,
  parameter int BLANK_CYC   = 5,
  parameter int WD_TIMEOUT  = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_en,
  input  logic              zcd_above_arm,
  input  logic              zcd_below_trig,
  input  logic              oc_flag,
  input  logic              ov_flag,
  input  logic              uv_flag,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              gate_drive
);

  localparam int BASE = CTRL_FLOOR + RAMP_OFFSET;

  logic trig, park, fire, busy, allow, start;
  start_cause_e cause;

  assign allow = !ov_flag && (32'(ctrl_word) > 32'(BASE));

  always_comb begin
    cause = START_NONE;
    if (seq_en && !busy && allow) begin
      if (trig)      cause = START_ZCD;
      else if (fire) cause = START_WDOG;
    end
  end

  assign start = (cause != START_NONE);

  pfc_zcd_arm u_arm (
    .clk   (clk),
    .rst   (rst),
    .en    (seq_en),
    .above (zcd_above_arm),
    .below (zcd_below_trig),
    .busy  (busy),
    .start (start),
    .trig  (trig),
    .park  (park)
  );

  pfc_restart_wdog #(.WD_TIMEOUT(WD_TIMEOUT)) u_wdog (
    .clk   (clk),
    .rst   (rst),
    .en    (seq_en),
    .park  (park),
    .uv    (uv_flag),
    .start (start),
    .fire  (fire)
  );

  pfc_ontime #(
    .CTRL_W    (CTRL_W),
    .BASE      (BASE),
    .RAMP_PEAK (RAMP_PEAK),
    .BLANK_CYC (BLANK_CYC)
  ) u_ontime (
    .clk    (clk),
    .rst    (rst),
    .en     (seq_en),
    .start  (start),
    .ctrl   (ctrl_word),
    .oc     (oc_flag),
    .ov     (ov_flag),
    .active (busy)
  );

  assign gate_drive = busy;

  p_disable_off_r1: assert property (@(posedge clk) disable iff (rst)
    !seq_en |=> !gate_drive);

  p_ov_no_start_r8: assert property (@(posedge clk) disable iff (rst)
    ov_flag |=> !$rose(gate_drive));

  p_floor_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_drive) |-> ($past(32'(ctrl_word)) > 32'(BASE)));

  p_start_source_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_drive) |-> $past(trig || fire));

endmodule

// File: tb/test_crm_pfc_ctrl.sv
module test_crm_pfc_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 24;
  localparam int PEAK       = 100;
  localparam int BLANK      = 5;
  localparam int TWD        = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, above = 1'b0, below = 1'b0;
  logic oc = 1'b0, ov = 1'b0, uv = 1'b0;
  logic [7:0] ctrl = 8'd60;
  logic gate;

  crm_pfc_ctrl i_crm_pfc_ctrl (
    .clk(clk), .rst(rst), .seq_en(en),
    .zcd_above_arm(above), .zcd_below_trig(below),
    .oc_flag(oc), .ov_flag(ov), .uv_flag(uv),
    .ctrl_word(ctrl), .gate_drive(gate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, n_rise = 0;

  typedef struct { string tag; int width; int start; } exp_t;
  exp_t sb[$];
  exp_t mon_e;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: measures each pulse and compares it to the scoreboard
  logic prev = 1'b0;
  int   st = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (gate && !prev) begin
        st = cyc;
        n_rise++;
      end
      if (!gate && prev) begin
        if (sb.size() == 0) begin
          n_chk++;
          n_fail++;
          $display("FAIL unexpected pulse: actual width %0d at %0d expected none", cyc - st, st);
        end else begin
          mon_e = sb.pop_front();
          check({mon_e.tag, " width"}, cyc - st, mon_e.width);
          if (mon_e.start >= 0) check({mon_e.tag, " start"}, st, mon_e.start);
        end
      end
    end
    prev = gate;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pulse(string tag, int w, int s);
    exp_t e;
    e.tag = tag; e.width = w; e.start = s;
    sb.push_back(e);
  endtask

  task automatic fire_zcd(output int t);
    @(negedge clk); above = 1'b1; below = 1'b0;
    @(negedge clk); above = 1'b0;
    @(negedge clk); below = 1'b1; t = cyc;
  endtask

  task automatic park_zcd();
    @(negedge clk); above = 1'b1; below = 1'b0;
  endtask

  task automatic drain(string tag);
    int i = 0;
    while (sb.size() != 0 && i < 1000) begin
      @(negedge clk);
      i++;
    end
    if (sb.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL %s missing pulse: actual 0 expected %0d", tag, sb.size());
      sb.delete();
    end
  endtask

  task automatic quiet(string tag, int n);
    int r0 = n_rise;
    tick(n);
    check({tag, " no pulse"}, n_rise - r0, 0);
  endtask

  initial begin
    int t, c1;
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t, c1;
    tick(5);
    check("R1 gate in reset", gate, 0);
    @(negedge clk); rst = 1'b0; en = 1'b1; above = 1'b1;
    tick(3);
    check("R1 gate after reset", gate, 0);

    // R2 / R4: start timing and width from control word
    ctrl = 8'd60; fire_zcd(t); expect_pulse("R2 R4 ctrl60", 36, t + 1); drain("R4");
    park_zcd();
    fire_zcd(t); expect_pulse("R4 repeat ctrl60", 36, t + 1); drain("R4");
    park_zcd();
    ctrl = 8'd30; fire_zcd(t); expect_pulse("R4 ctrl30", 6, t + 1); drain("R4");
    park_zcd();

    // R6: floor
    ctrl = 8'd25; fire_zcd(t); expect_pulse("R6 ctrl25", 1, t + 1); drain("R6");
    park_zcd();
    ctrl = 8'd24; fire_zcd(t); quiet("R6 ctrl24", 40);
    park_zcd();
    ctrl = 8'd0; fire_zcd(t); quiet("R6 ctrl0", 40);
    park_zcd();

    // R5: peak limit
    ctrl = 8'd123; fire_zcd(t); expect_pulse("R5 ctrl123", 99, t + 1); drain("R5");
    park_zcd();
    ctrl = 8'd124; fire_zcd(t); expect_pulse("R5 ctrl124", PEAK, t + 1); drain("R5");
    park_zcd();
    ctrl = 8'd200; fire_zcd(t); expect_pulse("R5 ctrl200", PEAK, t + 1); drain("R5");
    park_zcd();

    // R3: ignored trigger edges
    ctrl = 8'd100; fire_zcd(t); expect_pulse("R3 edge in pulse", 76, t + 1);
    tick(20); below = 1'b0; tick(2); above = 1'b1; tick(2); above = 1'b0; tick(2); below = 1'b1;
    drain("R3");
    tick(2); below = 1'b0; tick(2); below = 1'b1;
    quiet("R3 unarmed edge", 40);
    park_zcd();

    // R7: overcurrent and blanking
    oc = 1'b1; fire_zcd(t); expect_pulse("R7 oc held", BLANK + 1, t + 1); drain("R7");
    oc = 1'b0; park_zcd();
    fire_zcd(t); expect_pulse("R7 oc late", 20, t + 1); tick(20); oc = 1'b1; drain("R7");
    oc = 1'b0; park_zcd();
    fire_zcd(t); expect_pulse("R7 oc in blank", 76, t + 1);
    tick(2); oc = 1'b1; tick(2); oc = 1'b0; drain("R7");
    park_zcd();

    // R8: overvoltage
    ov = 1'b1; fire_zcd(t); quiet("R8 ov blocks", 40);
    ov = 1'b0;
    fire_zcd(t); expect_pulse("R8 resume", 76, t + 1); drain("R8");
    park_zcd();
    fire_zcd(t); expect_pulse("R8 ov ends", 15, t + 1); tick(15); ov = 1'b1; drain("R8");
    ov = 1'b0; park_zcd();

    // R9: watchdog restarts, R6 for watchdog requests, R10 parking
    ctrl = 8'd40; fire_zcd(t);
    expect_pulse("R9 first", 16, t + 1);
    expect_pulse("R9 second", 16, t + 1 + TWD);
    expect_pulse("R9 third", 16, t + 1 + 2 * TWD);
    drain("R9");
    ctrl = 8'd10; quiet("R6 watchdog floor", 700);
    ctrl = 8'd40; park_zcd();
    quiet("R10 parked", 700);

    // R11: undervoltage clears watchdog
    fire_zcd(t); expect_pulse("R11 lead", 16, t + 1); drain("R11");
    tick(60); uv = 1'b1; tick(500);
    @(negedge clk); uv = 1'b0; c1 = cyc;
    expect_pulse("R11 after uv", 16, c1 + TWD); drain("R11");
    park_zcd();

    // R1: sequencer disable
    ctrl = 8'd200; fire_zcd(t); expect_pulse("R1 disable cut", 10, t + 1);
    tick(10); en = 1'b0; drain("R1");
    quiet("R1 disabled", 400);
    en = 1'b1; below = 1'b0; tick(2); below = 1'b1;
    quiet("R1 unarmed after enable", 50);
    park_zcd();
    ctrl = 8'd60; fire_zcd(t); expect_pulse("R1 recovery", 36, t + 1); drain("R1");
    park_zcd();
    tick(5);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule